// File: doc/BRIEF.md
# Byte-Merging Posted Write Buffer

This block sits between a processor-side write port and a downstream drain sequencer. It posts writes so that the processor does not wait for the bus. Each incoming write names one 8-byte line by its line address and carries eight byte enables and 64 data bits. The block stores the write as an entry in a small in-order queue. Total storage is counted in 32-bit doubleword slots, and the default is five slots.

A short write can join the newest entry instead of opening a new one. It must be 1, 2 or 4 contiguous bytes, it must target the same line, and its first byte must sit directly above the highest byte that entry already holds. The queue therefore only grows forward through a line. No byte is ever rewritten, and no write overtakes an earlier one. The drain side sees the oldest entry with a valid/ready handshake. Along with that entry it gets a two-bit mask that says which doublewords of the entry carry data.

Top module: `merge_post_buffer`

## Requirements
- R1: After reset `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: `wr_ready` is 1 exactly when the number of doublewords the presented write touches (byte enables 0-3 form doubleword 0, byte enables 4-7 form doubleword 1) fits into the free slots. A write is taken on a clock edge with `wr_valid` and `wr_ready` both high. `full` is 1 when all DEPTH_DW slots are used.
- R3: An accepted write of 1, 2 or 4 contiguous enabled bytes to the same line as the newest entry, whose lowest enabled byte index equals that entry's highest enabled byte index plus one, joins that entry. The entry's enables become the union of both writes, and each byte lane holds the data of the write that enabled it. Bytes that no write enabled read as zero.
- R4: A write to a different line, or whose lowest enabled byte is at or below the highest held byte, or that leaves a gap above it, opens a new entry.
- R5: Entries leave in the order they arrived, one per edge with `rd_valid` and `rd_ready` high. While more than one entry is held and `rd_ready` is low, the presented entry does not change.
- R6: A write with all eight bytes enabled is stored as its own entry, uses two slots and never merges.
- R7: When the newest entry is also the only entry and `rd_ready` is high in the same cycle, an otherwise mergeable write opens a new entry instead.
- R8: `rd_dw_mask[0]` is the OR of `rd_be[3:0]` and `rd_dw_mask[1]` is the OR of `rd_be[7:4]`.
- R9: Occupancy counts the doublewords that hold an enabled byte. A merged entry that spans both halves counts two. `empty` is 1 when no slot is used. A push and a pop may occur on the same edge.
- R10: A write with no byte enabled is accepted and discarded, and the buffer is left unchanged.
- R11: A write whose enabled byte count is not 1, 2 or 4 (for example 3) never merges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_line | input | LINE_W | 8-byte line address of the write |
| wr_be | input | 8 | Byte enables of the write |
| wr_data | input | 64 | Write data, byte i in bits 8i+7:8i |
| full | output | 1 | All doubleword slots used |
| empty | output | 1 | No doubleword slot used |
| rd_valid | output | 1 | Oldest entry presented |
| rd_ready | input | 1 | Drain sequencer takes the presented entry |
| rd_line | output | LINE_W | Line address of the presented entry |
| rd_be | output | 8 | Byte enables of the presented entry |
| rd_data | output | 64 | Data of the presented entry |
| rd_dw_mask | output | 2 | Doublewords of the presented entry that carry data |

## Verification
The first pattern is an ascending chain of 1-, 2- and 1-byte writes through one line, plus a pair of 4-byte halves. These separate a correct merge from a block that never merges. Pairs that go backwards, repeat a byte, skip a byte, carry three bytes or change line separate the merge rule from one that is too loose. A mergeable write issued while the sole entry is being drained shows whether bytes are lost to an entry that is leaving. A long stream of mixed-size writes on distinct lines, with drain pressure toggling, shows whether slot accounting, stalling on full and ordering stay correct when pushes and pops meet on the same edge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int BYTES    = 8;
    localparam int DATA_W   = BYTES * 8;
    localparam int DW_BYTES = 4;
    localparam int DW_N     = BYTES / DW_BYTES;
    localparam int IDX_W    = $clog2(BYTES);

    // index of the lowest enabled byte
    function automatic logic [IDX_W-1:0] low_idx(input logic [BYTES-1:0] be);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = BYTES - 1; i >= 0; i--) begin
            if (be[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // index of the highest enabled byte
    function automatic logic [IDX_W-1:0] high_idx(input logic [BYTES-1:0] be);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (be[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // widen byte enables into a bit mask over the data word
    function automatic logic [DATA_W-1:0] lane_mask(input logic [BYTES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BYTES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // only power-of-two sizes up to a doubleword may join an entry
    function automatic logic mergeable_size(input logic [BYTES-1:0] be);
        int n;
        n = $countones(be);
        return (n == 1) || (n == 2) || (n == 4);
    endfunction

    function automatic logic is_contiguous(input logic [BYTES-1:0] be);
        logic [BYTES-1:0] s;
        s = be >> low_idx(be);
        return (be != '0) && ((s & (s + BYTES'(1))) == '0);
    endfunction
endpackage

// File: rtl/pwb_dw_slots.sv
module pwb_dw_slots
    import pwb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [BYTES-1:0] be,
    output logic [CNT_W-1:0] slots
);
    logic [DW_N-1:0] dw_hit;

    for (genvar g = 0; g < DW_N; g++) begin : g_dw
        assign dw_hit[g] = |be[g*DW_BYTES +: DW_BYTES];
    end

    always_comb begin
        slots = '0;
        for (int i = 0; i < DW_N; i++) begin
            slots = slots + CNT_W'(dw_hit[i]);
        end
    end
endmodule

// File: rtl/pwb_merge_rule.sv
module pwb_merge_rule
    import pwb_pkg::*;
#(
    parameter int LINE_W = 29
) (
    input  logic              open_ok,
    input  logic [LINE_W-1:0] open_line,
    input  logic [BYTES-1:0]  open_be,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [BYTES-1:0]  wr_be,
    output logic              merge_ok
);
    logic [IDX_W:0] next_byte;
    logic [IDX_W:0] first_byte;

    assign next_byte  = (IDX_W+1)'(high_idx(open_be)) + (IDX_W+1)'(1);
    assign first_byte = (IDX_W+1)'(low_idx(wr_be));

    assign merge_ok = open_ok
                   && (open_line == wr_line)
                   && mergeable_size(wr_be)
                   && is_contiguous(wr_be)
                   && (first_byte == next_byte);
endmodule

// File: rtl/merge_post_buffer.sv
module merge_post_buffer
    import pwb_pkg::*;
#(
    parameter int LINE_W   = 29,
    parameter int DEPTH_DW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              empty,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [LINE_W-1:0] rd_line,
    output logic [BYTES-1:0]  rd_be,
    output logic [DATA_W-1:0] rd_data,
    output logic [DW_N-1:0]   rd_dw_mask
);
    localparam int ENTRIES = DEPTH_DW;
    localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W   = $clog2(DEPTH_DW + DW_N + 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [BYTES-1:0]  be;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] mem;
        logic [PTR_W-1:0]     head;
        logic [PTR_W-1:0]     tail;
        logic [PTR_W:0]       count;
        logic [CNT_W-1:0]     used;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] newest;
    entry_t           head_e, tail_e;
    logic [BYTES-1:0] merged_be;
    logic [CNT_W-1:0] wr_slots, head_slots, tail_slots, mrg_slots;
    logic [CNT_W-1:0] add_slots, sub_slots;
    logic             pop, accept, open_ok, merge_ok, push_new;

    assign newest    = (st_q.tail == '0) ? PTR_W'(ENTRIES - 1) : st_q.tail - PTR_W'(1);
    assign head_e    = st_q.mem[st_q.head];
    assign tail_e    = st_q.mem[newest];
    assign merged_be = tail_e.be | wr_be;

    pwb_dw_slots #(.CNT_W(CNT_W)) u_wr_slots   (.be(wr_be),     .slots(wr_slots));
    pwb_dw_slots #(.CNT_W(CNT_W)) u_head_slots (.be(head_e.be), .slots(head_slots));
    pwb_dw_slots #(.CNT_W(CNT_W)) u_tail_slots (.be(tail_e.be), .slots(tail_slots));
    pwb_dw_slots #(.CNT_W(CNT_W)) u_mrg_slots  (.be(merged_be), .slots(mrg_slots));

    // the sole entry being drained this cycle is no longer open
    assign open_ok = (st_q.count != '0) && !((st_q.count == (PTR_W+1)'(1)) && rd_ready);

    pwb_merge_rule #(.LINE_W(LINE_W)) u_rule (
        .open_ok  (open_ok),
        .open_line(tail_e.line),
        .open_be  (tail_e.be),
        .wr_line  (wr_line),
        .wr_be    (wr_be),
        .merge_ok (merge_ok)
    );

    // a merge never needs more slots than the write alone, so this bound is safe
    assign wr_ready = (wr_slots + st_q.used) <= CNT_W'(DEPTH_DW);
    assign pop      = (st_q.count != '0) && rd_ready;
    assign accept   = wr_valid && wr_ready && (wr_be != '0);

    always_comb begin
        st_d      = st_q;
        add_slots = '0;
        sub_slots = '0;
        push_new  = 1'b0;
        if (pop) begin
            st_d.head = ptr_inc(st_q.head);
            sub_slots = head_slots;
        end
        if (accept) begin
            if (merge_ok) begin
                st_d.mem[newest].be   = merged_be;
                st_d.mem[newest].data = tail_e.data | (wr_data & lane_mask(wr_be));
                add_slots             = mrg_slots - tail_slots;
            end else begin
                st_d.mem[st_q.tail].line = wr_line;
                st_d.mem[st_q.tail].be   = wr_be;
                st_d.mem[st_q.tail].data = wr_data & lane_mask(wr_be);
                st_d.tail                = ptr_inc(st_q.tail);
                add_slots                = wr_slots;
                push_new                 = 1'b1;
            end
        end
        st_d.count = st_q.count + (PTR_W+1)'(push_new) - (PTR_W+1)'(pop);
        st_d.used  = st_q.used + add_slots - sub_slots;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = (st_q.count != '0);
    assign rd_line  = head_e.line;
    assign rd_be    = head_e.be;
    assign rd_data  = head_e.data;
    assign full     = (st_q.used == CNT_W'(DEPTH_DW));
    assign empty    = (st_q.used == '0);

    for (genvar g = 0; g < DW_N; g++) begin : g_mask
        assign rd_dw_mask[g] = |head_e.be[g*DW_BYTES +: DW_BYTES];
    end

    // R9
    used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CNT_W'(DEPTH_DW));

    // R2
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && (wr_be != '0)) |-> !wr_ready);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && (st_q.count > (PTR_W+1)'(1)))
        |=> ($stable(rd_line) && $stable(rd_be) && $stable(rd_data)));

    // R3
    be_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> ((rd_be & $past(rd_be)) == $past(rd_be)));

    // R8
    dw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_dw_mask != '0));
endmodule

// File: tb/merge_post_buffer_tb_top.sv
`timescale 1ns/1ps
module merge_post_buffer_tb_top;
    localparam int LW = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [LW-1:0] wr_line = '0;
    logic [7:0]    wr_be = 8'hFF;
    logic [63:0]   wr_data = '0;
    logic          full, empty, rd_valid;
    logic          rd_ready = 1'b0;
    logic [LW-1:0] rd_line;
    logic [7:0]    rd_be;
    logic [63:0]   rd_data;
    logic [1:0]    rd_dw_mask;

    always #4 clk = ~clk;

    merge_post_buffer #(.LINE_W(LW), .DEPTH_DW(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_line(wr_line), .wr_be(wr_be), .wr_data(wr_data), .full(full),
        .empty(empty), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_line(rd_line), .rd_be(rd_be), .rd_data(rd_data), .rd_dw_mask(rd_dw_mask)
    );

    typedef struct {
        logic [LW-1:0] line;
        logic [7:0]    be;
        logic [63:0]   data;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R5";
    bit    stream_done;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lanes(input logic [7:0] be);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [63:0] mkdata(input logic [LW-1:0] line, input logic [7:0] be);
        return {8{line[7:0] ^ be}} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    // merge rule written from the requirements
    function automatic bit may_join(input exp_t last, input logic [LW-1:0] line, input logic [7:0] be);
        int lo, hi, hold, n;
        lo = -1; hi = -1; hold = -1; n = 0;
        for (int i = 0; i < 8; i++) begin
            if (be[i]) begin
                if (lo < 0) lo = i;
                hi = i;
                n++;
            end
            if (last.be[i]) hold = i;
        end
        if (last.line != line) return 0;
        if (!(n == 1 || n == 2 || n == 4)) return 0;
        if (hi - lo + 1 != n) return 0;
        return lo == hold + 1;
    endfunction

    task automatic model_push(input logic [LW-1:0] line, input logic [7:0] be, input logic [63:0] d, input bit fresh);
        exp_t e;
        if (be == 8'h00) return;
        if (!fresh && exp_q.size() > 0 && may_join(exp_q[exp_q.size()-1], line, be)) begin
            e = exp_q[exp_q.size()-1];
            e.be   = e.be | be;
            e.data = e.data | (d & lanes(be));
            exp_q[exp_q.size()-1] = e;
        end else begin
            e.line = line; e.be = be; e.data = d & lanes(be);
            exp_q.push_back(e);
        end
    endtask

    task automatic wr(input logic [LW-1:0] line, input logic [7:0] be, input bit drain_now);
        logic [63:0] d;
        d = mkdata(line, be);
        @(negedge clk);
        wr_valid = 1'b1; wr_line = line; wr_be = be; wr_data = d;
        if (drain_now) rd_ready = 1'b1;
        #1;
        while (!wr_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        model_push(line, be, d, drain_now);
        #1;
        wr_valid = 1'b0;
        if (drain_now) rd_ready = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        rd_ready = 1'b1;
        for (int i = 0; i < 64 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        rd_ready = 1'b0;
        #2;
        check(empty && !rd_valid && exp_q.size() == 0, "R9 empty after drain",
              {empty, rd_valid, 32'(exp_q.size())}, {1'b1, 1'b0, 32'd0});
    endtask

    // monitor: compare each taken entry with the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                check(0, {cur_req, " R5 unexpected entry"}, {rd_line, rd_be}, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_line == e.line && rd_be == e.be && rd_data == e.data,
                      {cur_req, " R5 entry content/order"},
                      {rd_line, rd_be, rd_data}, {e.line, e.be, e.data});
                check(rd_dw_mask == {|e.be[7:4], |e.be[3:0]}, "R8 dword mask",
                      rd_dw_mask, {|e.be[7:4], |e.be[3:0]});
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        check(empty && !full && !rd_valid, "R1 reset state", {empty, full, rd_valid}, 3'b100);
        check(wr_ready, "R2 ready when empty", wr_ready, 1'b1);

        // R3 ascending chain through one line, then slot accounting
        cur_req = "R3";
        wr(7, 8'h08, 0); wr(7, 8'h30, 0); wr(7, 8'h40, 0); wr(7, 8'h80, 0);
        wr(8, 8'h01, 0); wr(9, 8'h01, 0);
        @(negedge clk); #1;
        check(!full, "R9 merged entry uses two slots", full, 1'b0);
        wr_be = 8'hFF; #1;
        check(!wr_ready, "R6 full write needs two slots", wr_ready, 1'b0);
        wr_be = 8'h01; #1;
        check(wr_ready, "R2 one free slot accepts byte", wr_ready, 1'b1);
        wr(10, 8'h01, 0);
        @(negedge clk); #1;
        check(full, "R9 full at five slots", full, 1'b1);
        wr_be = 8'h02; #1;
        check(!wr_ready, "R2 stall when full", wr_ready, 1'b0);
        drain();

        // R3 two 4-byte halves
        wr(11, 8'h0F, 0); wr(11, 8'hF0, 0);
        drain();

        // R4 non-merging pairs
        cur_req = "R4";
        wr(20, 8'h08, 0); wr(20, 8'h04, 0); drain();
        wr(21, 8'h08, 0); wr(21, 8'h08, 0); drain();
        wr(22, 8'h02, 0); wr(22, 8'h08, 0); drain();
        wr(24, 8'h01, 0); wr(25, 8'h02, 0); drain();

        // R11 three-byte write right above held byte
        cur_req = "R11";
        wr(23, 8'h08, 0); wr(23, 8'h70, 0); drain();

        // R6 full write then following byte
        cur_req = "R6";
        wr(28, 8'h01, 0); wr(28, 8'hFF, 0); drain();
        wr(29, 8'hFF, 0); wr(29, 8'h01, 0); drain();

        // R10 empty enables discarded
        cur_req = "R10";
        wr(30, 8'h00, 0);
        @(negedge clk); #1;
        check(empty && !rd_valid, "R10 no-enable write discarded", {empty, rd_valid}, 2'b10);

        // R7 sole entry being drained is closed
        cur_req = "R7";
        wr(50, 8'h01, 0);
        wr(50, 8'h02, 1);
        wr(50, 8'h04, 0);
        drain();

        // R9 streaming with concurrent push and pop
        cur_req = "R9";
        stream_done = 0;
        fork
            begin
                logic [7:0] pats [7] = '{8'h01, 8'h03, 8'h0F, 8'hF0, 8'hFF, 8'h18, 8'h80};
                for (int i = 0; i < 35; i++) wr(LW'(200 + i), pats[i % 7], 0);
                stream_done = 1;
            end
            begin
                int cyc;
                cyc = 0;
                while (!stream_done) begin
                    @(negedge clk);
                    rd_ready = (cyc % 3) != 0;
                    cyc++;
                end
            end
        join
        drain();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule